// File: doc/BRIEF.md
# Strobed Serial Word Transmitter

This block collects four bytes from a byte-valid input into one 32-bit word and sends that word out on a single serial data line, one bit per system clock. An active-low strobe stays low for exactly the 32 clocks of the transfer. The system clock is also driven out as the serial clock. A receiver can sample the data line on each falling edge of that clock while the strobe is low.

A free-running divider also runs from the same clock. It produces a parallel-side clock whose period is 128 system clocks. A send request starts a transfer only when a full word has been collected and no transfer is already running.

Top module: `serial_word_tx`

## Requirements
- R1: While `rst` is high at a rising edge, the block is cleared: `strobe_n`=1, `busy`=0, `ser_data`=0, `par_clk`=0, and the byte index, the word-complete flag and the shift register are all zero.
- R2: `par_clk` is the top bit of a 7-bit counter that advances on every clock. After reset it is low for 64 clocks, then high for 64 clocks, and the pattern repeats with a period of 128 clocks.
- R3: Bytes are stored in order of arrival. The first byte taken while `byte_vld`=1 fills word bits 7:0, the second fills 15:8, the third fills 23:16 and the fourth fills 31:24.
- R4: A rising edge with `send_req`=1, `busy`=0 and four bytes collected starts a transfer. A request made with fewer than four bytes collected is ignored. A word that has been sent cannot be sent again.
- R5: From the starting edge, `busy`=1 and `strobe_n`=0 for exactly 32 clocks. Then `busy`=0 and `strobe_n`=1.
- R6: The word is sent least significant bit first. Word bit k is on `ser_data` during the k-th clock after the starting edge, for k=0 to 31.
- R7: When no transfer is running, `strobe_n` stays high and `ser_data` stays low until the next accepted request.
- R8: A send request made while `busy`=1 has no effect on the running transfer and does not start another one.
- R9: `ser_clk` equals the system clock. `ser_data` changes only after a rising edge, so it is stable at every falling edge.
- R10: Bytes that arrive during a transfer do not change the word being sent. A byte that arrives after four bytes have been collected starts a new word as its bits 7:0 and clears the word-complete state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Byte to add to the word |
| byte_vld | input | 1 | Takes `byte_in` on this edge |
| send_req | input | 1 | Request to send the collected word |
| ser_data | output | 1 | Serial data, least significant bit first |
| ser_clk | output | 1 | Serial clock (copy of `clk`) |
| strobe_n | output | 1 | Low while a word is being shifted out |
| busy | output | 1 | High while a word is being shifted out |
| par_clk | output | 1 | System clock divided by 128 |

## Verification
The bench drives several word patterns: mixed bits, all ones, and words with only the end bits set. These show whether the byte order is correct and whether the bit order or the bit count is wrong. Send requests are also made with half a word collected, repeated during a transfer, and repeated after a word has been sent. These separate correct gating of the start from a block that starts too freely. Bytes are also loaded during a transfer, and a fifth byte is given; these show whether the word being shifted is kept apart from the word being collected. A model in the bench predicts every output on every clock, so any error in the divider phase or the strobe length is detected on the cycle where it occurs.

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic              send_req,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              strobe_n,
  output logic              busy,
  output logic              par_clk
);
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [DIV_W-1:0] HALF_M1  = {1'b0, {(DIV_W-1){1'b1}}};

  logic [DIV_W-1:0]  div_cnt;
  logic [IDX_W-1:0]  idx;
  logic              full;
  logic [WORD_W-1:0] asm_word;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic              start;

  assign start    = send_req && full && !busy;
  assign ser_data = shreg[0];
  assign ser_clk  = clk;
  assign strobe_n = !busy;
  assign par_clk  = div_cnt[DIV_W-1];

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      full     <= 1'b0;
      asm_word <= '0;
    end else begin
      if (byte_vld) begin
        asm_word[idx*BYTE_W +: BYTE_W] <= byte_in;
        idx  <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        full <= (idx == LAST_IDX);
      end else if (start) begin
        full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      shreg  <= asm_word;
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      shreg  <= shreg >> 1;
      bitcnt <= bitcnt + 1'b1;
      if (bitcnt == LAST_BIT) busy <= 1'b0;
    end
  end

  p_div_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (div_cnt == HALF_M1) |=> $rose(par_clk));

  p_start_gated_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(send_req) && $past(full)));

  p_first_bit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (bitcnt == '0));

  p_steady_count_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && bitcnt != LAST_BIT) |=> (busy && bitcnt == $past(bitcnt) + 1'b1));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_data);

  p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && !$past(byte_vld) |-> !full);
endmodule

// File: tb/tb_serial_word_tx.sv
module tb_serial_word_tx;
  localparam int CLK_P = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = '0;
  logic       byte_vld = 1'b0;
  logic       send_req = 1'b0;
  logic       ser_data, ser_clk, strobe_n, busy, par_clk;

  serial_word_tx dut (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .send_req(send_req), .ser_data(ser_data), .ser_clk(ser_clk),
    .strobe_n(strobe_n), .busy(busy), .par_clk(par_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model
  logic [7:0]  m_q[$];
  logic        m_ready = 1'b0;
  logic        m_busy = 1'b0;
  int          m_pos = 0;
  logic [31:0] m_word = '0;
  int          m_div = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_q.delete(); m_ready = 1'b0; m_busy = 1'b0; m_pos = 0; m_div = 0; m_word = '0;
    end else begin
      bit st;
      st = send_req && m_ready && !m_busy;
      m_div = (m_div + 1) % 128;
      if (m_busy) begin
        m_pos++;
        if (m_pos == 32) m_busy = 1'b0;
      end
      if (st) begin
        m_word = '0;
        for (int i = 0; i < 4; i++) m_word[i*8 +: 8] = m_q[i];
        m_busy = 1'b1; m_pos = 0; m_ready = 1'b0;
      end
      if (byte_vld) begin
        if (m_q.size() == 4) m_q.delete();
        m_q.push_back(byte_in);
        m_ready = (m_q.size() == 4);
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("strobe_n (R5)", strobe_n, !m_busy);
      chk("busy (R5)", busy, m_busy);
      chk("ser_data (R6)", ser_data, m_busy ? m_word[m_pos] : 1'b0);
      chk("par_clk (R2)", par_clk, m_div >= 64);
      chk("ser_clk low (R9)", ser_clk, 1'b0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    byte_in = b; byte_vld = 1'b1;
    tick(1);
    byte_vld = 1'b0;
  endtask

  task automatic load_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) put_byte(w[i*8 +: 8]);
  endtask

  task automatic send();
    send_req = 1'b1; tick(1); send_req = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tag = "R3"; load_word(32'h9234_5673); send(); tick(40);
    tag = "R7"; tick(20);
    tag = "R4"; put_byte(8'hA5); put_byte(8'h3C); send(); tick(5);
    put_byte(8'h0F); put_byte(8'hF0); send(); tick(36);
    send(); tick(10);                        // R4: no second send of same word
    tag = "R8"; load_word(32'hFFFF_FFFF); send();
    for (int i = 0; i < 40; i++) begin send_req = 1'b1; tick(1); end
    send_req = 1'b0; tick(3);
    tag = "R10"; load_word(32'h8000_0001); send(); tick(2);
    load_word(32'h1357_9BDF); tick(30); send(); tick(36);
    load_word(32'h2468_ACE0); put_byte(8'h77); send(); tick(5);
    tag = "R6"; put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
    byte_in = 8'h80; byte_vld = 1'b1; send_req = 1'b1; tick(1);
    byte_vld = 1'b0; tick(1); send_req = 1'b0; tick(40);
    tag = "R9"; tick(150);
    tag = "R1"; rst = 1'b1; tick(2); rst = 1'b0; tick(70);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule